// File: doc/BRIEF.md
# Sideband request strobe serializer

This block carries 16-bit sideband address requests from a master to a target over an 8-bit lane. The lane moves eight bytes in each common-clock period. A request is split into an upper byte and a lower byte. The upper byte goes out in a slot latched by the rising edge of a first strobe. The lower byte goes out in the next slot, which a second strobe latches. The two strobes take turns slot by slot. Any slot that carries no request byte carries a NOP byte.

The transmitter takes requests through a valid/ready handshake. A request may begin in any of the four first-strobe slots of a common period. The transmitter also controls the strobes. When the master deasserts `run`, both strobes stop low. When `run` returns, the first strobe rises one fast cycle ahead of the second. The receiver detects strobe rising edges and pairs bytes only from a first-strobe slot onward. It drops NOP bytes and presents each rebuilt request as a one-cycle pulse.

Everything is clocked by one fast clock at eight times the common rate. A free-running slot counter marks the common-clock phase.

Top module: `sbreq_link`

## Requirements
- R1: While reset is high and on the first cycle after it, both strobes are low, the lane holds the NOP code 8'hFF, and `rsp_valid` is low.
- R2: `cc_mark` is high for exactly one fast cycle in every eight: slot 0 of each common period, with the first slot 0 on the first cycle after reset.
- R3: While strobing, the first strobe is high during even slots (0, 2, 4, 6) and the second strobe is high during odd slots. The two strobes are never high in the same cycle.
- R4: Every slot that carries no request byte carries 8'hFF, and the lane holds 8'hFF whenever both strobes are low.
- R5: `req_ready` is high only in the cycle that precedes an even slot, and only while `run` is high. A request handed over in that cycle starts in that even slot, so a request can start in any of the four even slots.
- R6: An accepted request puts bits [15:8] on the lane in its even slot with the first strobe high. It puts bits [7:0] in the next odd slot with the second strobe high.
- R7: While `run` is low, the strobes go low from the next even slot and stay low. A request whose upper byte is already on the lane always completes its lower byte first.
- R8: After a stop, strobing resumes at an even slot. The first strobe rises there, and the second strobe rises exactly one fast cycle later. The second strobe never rises unless the first strobe was high in the preceding cycle.
- R9: The receiver emits every request whose upper byte is not 8'hFF exactly once, in order, with its 16 bits intact, as a one-cycle `rsp_valid` pulse.
- R10: A byte of 8'hFF latched by the first strobe starts no request. A request whose upper byte is 8'hFF is therefore discarded and produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight cycles per common period |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Strobing enable; low stops both strobes |
| req_valid | input | 1 | Request offered by the master |
| req_data | input | 16 | Request value |
| req_ready | output | 1 | Request taken on this edge if valid |
| cc_mark | output | 1 | High in slot 0 of each common period |
| sb_lane | output | 8 | Serialized sideband byte lane |
| sb_stb_f | output | 1 | First strobe, owns even slots |
| sb_stb_s | output | 1 | Second strobe, owns odd slots |
| rsp_valid | output | 1 | Rebuilt request present for one cycle |
| rsp_data | output | 16 | Rebuilt request value |

## Verification
The embedded assertions check five rules on every cycle. The two strobes are never high together. The lane idles at NOP while both strobes are low. A second-strobe rise always follows a first-strobe high cycle. A non-NOP upper byte is always followed by the second strobe. A handshake always lands its upper byte in the next slot. Whole-request properties can only be shown by the bench's scenarios: no loss, no duplication, in-order delivery, dropping of requests whose upper byte is 8'hFF, and correct stop/restart across random run toggling. The bench tracks these with a slot-accurate model and a scoreboard.

// File: rtl/sbreq_pkg.sv
package sbreq_pkg;
  localparam int unsigned SB_BYTE_W    = 8;
  localparam int unsigned SB_SLOT_LOG2 = 3;
  localparam logic [SB_BYTE_W-1:0] SB_NOP = '1;

  function automatic logic is_nop(input logic [SB_BYTE_W-1:0] b);
    return b == SB_NOP;
  endfunction
endpackage

// File: rtl/sbreq_tx.sv
module sbreq_tx
  import sbreq_pkg::*;
#(
  parameter int unsigned BYTE_W    = SB_BYTE_W,
  parameter int unsigned SLOT_LOG2 = SB_SLOT_LOG2,
  parameter logic [BYTE_W-1:0] NOP = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  req_valid,
  input  logic [2*BYTE_W-1:0]   req_data,
  output logic                  req_ready,
  output logic                  cc_mark,
  output logic [BYTE_W-1:0]     lane,
  output logic                  stb_f,
  output logic                  stb_s
);
  localparam int unsigned REQ_W = 2 * BYTE_W;

  logic [SLOT_LOG2-1:0] slot;
  logic                 running;
  logic                 pend;
  logic [BYTE_W-1:0]    lo_q;
  logic                 next_even;
  logic                 take;

  // registers update toward slot+1; that slot is even when the current one is odd
  assign next_even = slot[0];
  assign req_ready = next_even & run;
  assign take      = req_ready & req_valid;
  assign cc_mark   = (slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      running <= 1'b0;
      pend    <= 1'b0;
      lo_q    <= NOP;
      lane    <= NOP;
      stb_f   <= 1'b0;
      stb_s   <= 1'b0;
    end else begin
      slot <= slot + 1'b1;
      if (next_even) begin
        stb_s <= 1'b0;
        if (run) begin
          running <= 1'b1;
          stb_f   <= 1'b1;
          pend    <= take;
          lane    <= take ? req_data[REQ_W-1:BYTE_W] : NOP;
          lo_q    <= req_data[BYTE_W-1:0];
        end else begin
          running <= 1'b0;
          stb_f   <= 1'b0;
          pend    <= 1'b0;
          lane    <= NOP;
        end
      end else begin
        stb_f <= 1'b0;
        stb_s <= running;
        lane  <= (running && pend) ? lo_q : NOP;
        pend  <= 1'b0;
      end
    end
  end

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (rst)
    !(stb_f && stb_s));

  p_idle_lane_nop_r4: assert property (@(posedge clk) disable iff (rst)
    (!stb_f && !stb_s) |-> (lane == NOP));

  p_second_after_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(stb_s) |-> $past(stb_f));

  p_low_byte_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (stb_f && lane != NOP) |=> stb_s);

  p_accept_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (stb_f && lane == $past(req_data[REQ_W-1:BYTE_W])));
endmodule

// File: rtl/sbreq_rx.sv
module sbreq_rx
  import sbreq_pkg::*;
#(
  parameter int unsigned BYTE_W = SB_BYTE_W,
  parameter logic [BYTE_W-1:0] NOP = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BYTE_W-1:0]     lane,
  input  logic                  stb_f,
  input  logic                  stb_s,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_data
);
  logic              f_q, s_q;
  logic              have_hi;
  logic [BYTE_W-1:0] hi_q;
  logic              rise_f, rise_s;

  assign rise_f = stb_f & ~f_q;
  assign rise_s = stb_s & ~s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q       <= 1'b0;
      s_q       <= 1'b0;
      have_hi   <= 1'b0;
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      f_q       <= stb_f;
      s_q       <= stb_s;
      rsp_valid <= 1'b0;
      if (rise_f) begin
        have_hi <= (lane != NOP);
        hi_q    <= lane;
      end else if (rise_s) begin
        if (have_hi) begin
          rsp_valid <= 1'b1;
          rsp_data  <= {hi_q, lane};
        end
        have_hi <= 1'b0;
      end
    end
  end

  p_pair_complete_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(have_hi) && $past(rise_s)));

  p_nop_no_start_r10: assert property (@(posedge clk) disable iff (rst)
    (rise_f && lane == NOP) |=> !have_hi);
endmodule

// File: rtl/sbreq_link.sv
module sbreq_link
  import sbreq_pkg::*;
#(
  parameter int unsigned BYTE_W    = SB_BYTE_W,
  parameter int unsigned SLOT_LOG2 = SB_SLOT_LOG2,
  parameter logic [BYTE_W-1:0] NOP = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                req_valid,
  input  logic [2*BYTE_W-1:0] req_data,
  output logic                req_ready,
  output logic                cc_mark,
  output logic [BYTE_W-1:0]   sb_lane,
  output logic                sb_stb_f,
  output logic                sb_stb_s,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_data
);
  sbreq_tx #(.BYTE_W(BYTE_W), .SLOT_LOG2(SLOT_LOG2), .NOP(NOP)) tx_i (
    .clk(clk), .rst(rst), .run(run),
    .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
    .cc_mark(cc_mark), .lane(sb_lane), .stb_f(sb_stb_f), .stb_s(sb_stb_s)
  );

  sbreq_rx #(.BYTE_W(BYTE_W), .NOP(NOP)) rx_i (
    .clk(clk), .rst(rst), .lane(sb_lane), .stb_f(sb_stb_f), .stb_s(sb_stb_s),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/sbreq_link_tb_top.sv
module sbreq_link_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_data = '0;
  logic        req_ready, cc_mark, sb_stb_f, sb_stb_s, rsp_valid;
  logic [7:0]  sb_lane;
  logic [15:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sbreq_link dut_i (
    .clk(clk), .rst(rst), .run(run), .req_valid(req_valid), .req_data(req_data),
    .req_ready(req_ready), .cc_mark(cc_mark), .sb_lane(sb_lane),
    .sb_stb_f(sb_stb_f), .sb_stb_s(sb_stb_s),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // bench model state, derived from the requirements
  logic [15:0] sb_q[$];
  int   b_slot = 0;
  bit   m_run = 0, m_pend = 0, e_f = 0, e_s = 0;
  logic [7:0] e_lane = 8'hFF, m_lo = 8'hFF;
  bit   p_f = 0, p_s = 0;
  int   n_rsp = 0, n_push = 0;

  function automatic bit slot_next_even(input int s);
    return (s % 2) == 1;
  endfunction

  task automatic cycle(input bit r, input bit v, input logic [15:0] d);
    bit acc;
    // outputs of the previous edge
    chk(sb_stb_f == e_f, "R3", sb_stb_f, e_f);
    chk(sb_stb_s == e_s, "R7", sb_stb_s, e_s);
    chk(sb_lane == e_lane, "R6", sb_lane, e_lane);
    chk(cc_mark == (b_slot == 0), "R2", cc_mark, b_slot == 0);
    if (!sb_stb_f && !sb_stb_s) chk(sb_lane == 8'hFF, "R4", sb_lane, 8'hFF);
    if (sb_stb_s && !p_s) chk(p_f, "R8", p_f, 1);
    if (rsp_valid) begin
      n_rsp++;
      if (sb_q.size() == 0) chk(0, "R10", rsp_data, 0);
      else begin
        logic [15:0] w;
        w = sb_q.pop_front();
        chk(rsp_data == w, "R9", rsp_data, w);
      end
    end
    p_f = sb_stb_f; p_s = sb_stb_s;
    // drive
    run = r; req_valid = v; req_data = d;
    #1;
    chk(req_ready == (slot_next_even(b_slot) && r), "R5", req_ready, slot_next_even(b_slot) && r);
    acc = v && req_ready;
    if (slot_next_even(b_slot)) begin
      e_s = 0;
      if (r) begin
        m_run = 1; e_f = 1; m_pend = acc;
        e_lane = acc ? d[15:8] : 8'hFF; m_lo = d[7:0];
        if (acc && d[15:8] != 8'hFF) begin sb_q.push_back(d); n_push++; end
      end else begin
        m_run = 0; e_f = 0; m_pend = 0; e_lane = 8'hFF;
      end
    end else begin
      e_f = 0; e_s = m_run;
      e_lane = (m_run && m_pend) ? m_lo : 8'hFF;
      m_pend = 0;
    end
    @(posedge clk);
    b_slot = (b_slot + 1) % 8;
    @(negedge clk);
  endtask

  initial begin
    bit r;
    int vp;
    void'($urandom(32'd1234));
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R1 reset state
    chk(!sb_stb_f && !sb_stb_s, "R1", {sb_stb_f, sb_stb_s}, 0);
    chk(sb_lane == 8'hFF, "R1", sb_lane, 8'hFF);
    chk(!rsp_valid, "R1", rsp_valid, 0);
    rst = 0;
    // directed: back-to-back in every even slot (R5, R6)
    for (int i = 0; i < 16; i++) cycle(1, 1, 16'h1200 + 16'(i));
    // directed: upper byte NOP is dropped (R10)
    for (int i = 0; i < 4; i++) cycle(1, 1, (i == 1) ? 16'hFF5A : 16'h3400 + 16'(i));
    // directed: stop then restart (R7, R8)
    for (int i = 0; i < 12; i++) cycle(0, 1, 16'h5555);
    for (int i = 0; i < 12; i++) cycle(1, 1, 16'h6600 + 16'(i));
    cycle(1, 0, 16'h0);
    cycle(0, 0, 16'h0);
    for (int i = 0; i < 9; i++) cycle(1, 0, 16'h0);
    // random
    r = 1; vp = 50;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      if ($urandom_range(39) == 0) r = !r;
      if ($urandom_range(99) == 0) vp = $urandom_range(100);
      d = 16'($urandom());
      if ($urandom_range(30) == 0) d[15:8] = 8'hFF;
      cycle(r, $urandom_range(99) < vp, d);
    end
    for (int i = 0; i < 8; i++) cycle(0, 0, 16'h0);
    chk(n_rsp == n_push, "R9", n_rsp, n_push);
    chk(sb_q.size() == 0, "R9", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule